// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block produces the clock waveform for an I2C controller, and it can also act as the SDA setup timer on the target side. The low and high widths of SCL come from two 8-bit timing inputs. Both widths are counted in cycles of the reference clock, and each phase always gets a fixed allowance of five extra cycles to cover synchronization and response latency. With a 26.25 MHz reference, the value 0x7F in both fields gives phases of about 5 µs (standard mode). The pair high 0x13 / low 0x26 suits fast mode, and the pair high 0x06 / low 0x0B suits fast-mode-plus.

SCL is driven as an open-drain line. The enable output pulls the line low, and releasing the enable lets the pull-up raise it. The high-phase counter moves forward only on cycles where the sampled line reads high, so a target that stretches the clock makes the released period longer. Two one-cycle strobes tell the data path when to act. The drive strobe marks when SDA may change. The sample strobe marks when SDA should be captured.

In target mode, a request from idle holds SCL low for the low-time count plus five cycles and then releases the line. The data path presents SDA during that wait.

Top module: `scl_pulse_gen`

## Requirements
- R1: A controller low phase keeps `scl_oe` at 1 for exactly `lo_cfg`+5 consecutive cycles.
- R2: A controller high phase keeps `scl_oe` at 0 until the sampled line has read high on exactly `hi_cfg`+5 cycles. `sample_stb` pulses in the last of those cycles.
- R3: The high phase does not count cycles in which `scl_in` reads 0. A stretch of N cycles makes the released period N cycles longer, and the count of cycles where the line reads high stays the same.
- R4: With both fields at 0x7F, each phase lasts 132 cycles. High 0x13 / low 0x26 gives 24 / 43 cycles. High 0x06 / low 0x0B gives 11 / 16 cycles.
- R5: Each phase uses the field value present in the cycle before it starts. Changing a field during a phase has no effect on the length of that phase.
- R6: `drive_stb` is high only in the first cycle of each low or setup phase. `sample_stb` is high only in the last counted high cycle, while `scl_oe` is 0 and `scl_in` is 1.
- R7: With no request, `scl_oe` stays 0. `xfer_req` is examined only in idle and at the end of a high phase. If `xfer_req` is 0 at that end, the block returns to idle with the line released.
- R8: `tgt_go` in idle with `xfer_req` at 0 holds `scl_oe` at 1 for `lo_cfg`+5 cycles, with `drive_stb` in the first of them, then releases SCL and returns to idle without a high phase. When both requests are present in idle, `xfer_req` wins.
- R9: While `rst` is 1, `scl_oe`, `drive_stb` and `sample_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cfg | input | 8 | High-phase count, before the fixed +5 |
| lo_cfg | input | 8 | Low-phase and target setup count, before the fixed +5 |
| xfer_req | input | 1 | Keep generating controller clock cycles |
| tgt_go | input | 1 | Start one target SDA setup wait |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | Open-drain pull-down enable for SCL |
| drive_stb | output | 1 | One-cycle strobe: SDA may change |
| sample_stb | output | 1 | One-cycle strobe: sample SDA |

## Verification
On every cycle, the assertions check several things. Each pulled-low run has the length of the low field that was captured when the run began. Each sample strobe comes after the programmed number of line-high cycles. The strobes occur only at the correct phase edges. The line stays released while no request is present.

Some behaviours can only be shown by the bench's scenarios:
- that the block holds its clock through a stretch of several cycles;
- that field writes in the middle of a phase are ignored;
- that the three example speed settings produce their exact widths;
- that the target wait ends in idle rather than in a high phase;
- that the controller request wins when both requests arrive together.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int CFG_W    = 8;
    localparam int SYNC_PAD = 5;
    localparam int CNT_W    = $clog2((1 << CFG_W) + SYNC_PAD);

    typedef logic [CFG_W-1:0] cfg_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOW    = 2'd1,
        PH_HIGH   = 2'd2,
        PH_TSETUP = 2'd3
    } phase_e;

    typedef struct packed {
        logic load;
        cnt_t preset;
        logic dec;
    } ctr_cmd_t;

    // Counter preset: counts down to zero, so a phase of f+PAD cycles loads f+PAD-1.
    function automatic cnt_t phase_preset(cfg_t f);
        return cnt_t'(f) + cnt_t'(SYNC_PAD - 1);
    endfunction

    function automatic logic pulls_low(phase_e p);
        return (p == PH_LOW) || (p == PH_TSETUP);
    endfunction

endpackage

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] preset,
    input  logic         dec,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= preset;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cfg_t     hi_cfg,
    input  cfg_t     lo_cfg,
    input  logic     xfer_req,
    input  logic     tgt_go,
    input  logic     scl_in,
    input  logic     expired,
    output ctr_cmd_t cmd,
    output phase_e   phase,
    output logic     drive_stb,
    output logic     sample_stb
);
    phase_e ph_q, ph_d;
    logic   first_q;
    logic   high_done;

    assign high_done = (ph_q == PH_HIGH) && expired && scl_in;

    always_comb begin
        ph_d = ph_q;
        cmd  = '0;
        unique case (ph_q)
            PH_IDLE: begin
                if (xfer_req) begin
                    ph_d       = PH_LOW;
                    cmd.load   = 1'b1;
                    cmd.preset = phase_preset(lo_cfg);
                end else if (tgt_go) begin
                    ph_d       = PH_TSETUP;
                    cmd.load   = 1'b1;
                    cmd.preset = phase_preset(lo_cfg);
                end
            end
            PH_LOW: begin
                cmd.dec = 1'b1;
                if (expired) begin
                    ph_d       = PH_HIGH;
                    cmd.load   = 1'b1;
                    cmd.preset = phase_preset(hi_cfg);
                end
            end
            PH_HIGH: begin
                cmd.dec = scl_in;
                if (high_done) begin
                    if (xfer_req) begin
                        ph_d       = PH_LOW;
                        cmd.load   = 1'b1;
                        cmd.preset = phase_preset(lo_cfg);
                    end else begin
                        ph_d = PH_IDLE;
                    end
                end
            end
            PH_TSETUP: begin
                cmd.dec = 1'b1;
                if (expired) ph_d = PH_IDLE;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            first_q <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            first_q <= cmd.load && pulls_low(ph_d);
        end
    end

    assign phase      = ph_q;
    assign drive_stb  = first_q;
    assign sample_stb = high_done;
endmodule

// File: rtl/scl_pulse_gen.sv
module scl_pulse_gen
    import scl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] hi_cfg,
    input  logic [7:0] lo_cfg,
    input  logic       xfer_req,
    input  logic       tgt_go,
    input  logic       scl_in,
    output logic       scl_oe,
    output logic       drive_stb,
    output logic       sample_stb
);
    ctr_cmd_t cmd;
    phase_e   phase;
    logic     expired;

    scl_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .hi_cfg     (cfg_t'(hi_cfg)),
        .lo_cfg     (cfg_t'(lo_cfg)),
        .xfer_req   (xfer_req),
        .tgt_go     (tgt_go),
        .scl_in     (scl_in),
        .expired    (expired),
        .cmd        (cmd),
        .phase      (phase),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb)
    );

    scl_phase_ctr #(.W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (cmd.load),
        .preset  (cmd.preset),
        .dec     (cmd.dec),
        .expired (expired)
    );

    assign scl_oe = pulls_low(phase);
endmodule

// File: rtl/scl_pulse_gen_chk.sv
module scl_pulse_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] hi_cfg,
    input logic [7:0] lo_cfg,
    input logic       xfer_req,
    input logic       tgt_go,
    input logic       scl_in,
    input logic       scl_oe,
    input logic       drive_stb,
    input logic       sample_stb
);
    logic [7:0]  prev_hi, prev_lo;
    logic [15:0] low_run, hi_run, exp_low, exp_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_hi <= '0;
            prev_lo <= '0;
            low_run <= '0;
            hi_run  <= '0;
            exp_low <= '0;
            exp_hi  <= '0;
        end else begin
            prev_hi <= hi_cfg;
            prev_lo <= lo_cfg;
            low_run <= scl_oe ? low_run + 16'd1 : 16'd0;
            if (scl_oe)      hi_run <= '0;
            else if (scl_in) hi_run <= hi_run + 16'd1;
            if (drive_stb) exp_low <= 16'(prev_lo) + 16'd5;
            if (!scl_oe && $past(scl_oe)) exp_hi <= 16'(prev_hi) + 16'd5;
        end
    end

    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_oe) |-> (low_run == exp_low));                    // R1

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (hi_run + 16'd1 == exp_hi));                 // R2

    AST_DRIVE_EDGE: assert property (@(posedge clk) disable iff (rst)
        drive_stb |-> (scl_oe && !$past(scl_oe)));                  // R6

    AST_SAMPLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (!scl_oe && scl_in && !drive_stb));          // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!$past(xfer_req) && !$past(tgt_go) && !$past(scl_oe)) |-> !scl_oe); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!scl_oe && !drive_stb && !sample_stb));            // R9
endmodule

bind scl_pulse_gen scl_pulse_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hi_cfg     (hi_cfg),
    .lo_cfg     (lo_cfg),
    .xfer_req   (xfer_req),
    .tgt_go     (tgt_go),
    .scl_in     (scl_in),
    .scl_oe     (scl_oe),
    .drive_stb  (drive_stb),
    .sample_stb (sample_stb)
);

// File: tb/tb_scl_pulse_gen.sv
module tb_scl_pulse_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] hi_cfg = 8'h7F;
    logic [7:0] lo_cfg = 8'h7F;
    logic       xfer_req = 1'b0;
    logic       tgt_go = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in;
    logic       scl_oe, drive_stb, sample_stb;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    assign scl_in = !scl_oe && !stretch;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_pulse_gen dut (
        .clk(clk), .rst(rst), .hi_cfg(hi_cfg), .lo_cfg(lo_cfg),
        .xfer_req(xfer_req), .tgt_go(tgt_go), .scl_in(scl_in),
        .scl_oe(scl_oe), .drive_stb(drive_stb), .sample_stb(sample_stb)
    );

    function automatic int phase_len(logic [7:0] f);
        return int'(f) + 5;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    // One controller clock cycle with optional stretch and mid-phase field writes.
    task automatic run_cycle(input logic [7:0] hi, input logic [7:0] lo,
                             input int stretch_n, input bit scramble);
        int n;
        int rel;
        int hcnt;
        int guard;
        int left;
        logic [7:0] hi_used;
        hi_cfg   = hi;
        lo_cfg   = lo;
        xfer_req = 1'b1;
        tick();
        check(scl_oe == 1'b1, "R7 start pulls low", int'(scl_oe), 1);
        check(drive_stb == 1'b1, "R6 drive strobe at low start", int'(drive_stb), 1);
        xfer_req = 1'b0;
        if (scramble) lo_cfg = lo ^ 8'hA5;   // R5: write during low phase
        hi_used = hi_cfg;
        n = 0;
        guard = 0;
        while (scl_oe && guard < 1000) begin
            n++;
            guard++;
            tick();
        end
        check(n == phase_len(lo), "R1 low width", n, phase_len(lo));
        if (scramble) hi_cfg = hi ^ 8'h3C;   // R5: write during high phase
        rel   = 0;
        hcnt  = 0;
        left  = stretch_n;
        guard = 0;
        while (guard < 1000) begin
            stretch = (left > 0);
            if (left > 0) left--;
            #1;
            check(scl_oe == 1'b0, "R3 released while stretched or high", int'(scl_oe), 0);
            rel++;
            if (scl_in) hcnt++;
            if (sample_stb) break;
            guard++;
            tick();
        end
        stretch = 1'b0;
        check(hcnt == phase_len(hi_used), "R2 high width", hcnt, phase_len(hi_used));
        check(rel == phase_len(hi_used) + stretch_n, "R3 stretched release", rel,
              phase_len(hi_used) + stretch_n);
        tick();
        check(scl_oe == 1'b0 && sample_stb == 1'b0, "R7 stop returns idle",
              int'(scl_oe), 0);
        repeat (3) tick();
        check(scl_oe == 1'b0, "R7 idle stays released", int'(scl_oe), 0);
    endtask

    task automatic run_target(input logic [7:0] lo);
        int n;
        int guard;
        lo_cfg = lo;
        tgt_go = 1'b1;
        tick();
        tgt_go = 1'b0;
        check(drive_stb == 1'b1, "R8 drive strobe at setup start", int'(drive_stb), 1);
        n = 0;
        guard = 0;
        while (scl_oe && guard < 1000) begin
            n++;
            guard++;
            tick();
        end
        check(n == phase_len(lo), "R8 setup width", n, phase_len(lo));
        n = 0;
        repeat (int'(hi_cfg) + 8) begin
            if (sample_stb || scl_oe) n++;
            tick();
        end
        check(n == 0, "R8 no high phase after setup", n, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int seen;
        process::self().srandom(32'd1234);
        repeat (3) tick();
        check(scl_oe == 1'b0 && drive_stb == 1'b0 && sample_stb == 1'b0,
              "R9 reset state", int'(scl_oe), 0);
        rst = 1'b0;
        repeat (4) tick();
        check(scl_oe == 1'b0, "R7 idle after reset", int'(scl_oe), 0);

        // R4: example speed settings
        run_cycle(8'h7F, 8'h7F, 0, 1'b0);
        run_cycle(8'h13, 8'h26, 0, 1'b0);
        run_cycle(8'h06, 8'h0B, 0, 1'b0);
        // corners
        run_cycle(8'h00, 8'h00, 0, 1'b0);
        run_cycle(8'hFF, 8'hFF, 0, 1'b0);
        // R3 stretching
        run_cycle(8'h06, 8'h0B, 7, 1'b0);
        run_cycle(8'h00, 8'h02, 1, 1'b0);
        // R5 mid-phase writes
        run_cycle(8'h13, 8'h26, 2, 1'b1);
        run_cycle(8'h00, 8'hFF, 0, 1'b1);
        // R8 target setup
        run_target(8'h0B);
        run_target(8'h00);

        // R8 priority: both requests in idle gives a controller cycle
        hi_cfg = 8'h02;
        lo_cfg = 8'h03;
        xfer_req = 1'b1;
        tgt_go = 1'b1;
        tick();
        xfer_req = 1'b0;
        tgt_go = 1'b0;
        seen = 0;
        repeat (40) begin
            if (sample_stb) seen++;
            tick();
        end
        check(seen == 1, "R8 controller request wins", seen, 1);

        // random mix
        for (int i = 0; i < 20; i++) begin
            run_cycle(8'($urandom), 8'($urandom), int'($urandom_range(0, 6)),
                      1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule